// File: doc/BRIEF.md
# Fastlock Charge-Pump Current Controller

This block decides which of two programmed 3-bit charge-pump current codes reaches the pump. A gain bit selects between them. The gain bit is written through a one-cycle strobe. Two control bits decide whether the gain bit simply holds its value or, in timed mode, clears itself after a programmed number of phase-detector cycles. The timed count is held in a small down-counter that advances only on the phase-detector tick input.

The same block also produces the power-down and pump high-impedance controls. A low chip-enable pin powers down at once. The two power-down bits can ask for an immediate power-down or for one that is deferred until the next charge-pump event, which arrives as a one-cycle strobe. While the block is powered down, the timeout counter is held in its idle state. Both explicit tri-state requests also float the pump.

Top module: `fastlock_cp_ctrl`

## Requirements
- R1: `cp_code` equals `code_lo` while the gain bit is 0 and `code_hi` while it is 1. When the fastlock enable is 0, or the fastlock mode bit is 0, the gain bit changes only through writes; phase-detector ticks leave it unchanged.
- R2: A cycle with `gain_wr` high loads `gain_val` into the gain bit, and `gain_out` shows the new value from the next cycle on.
- R3: When `fl_en` and `fl_mode` are both 1, writing gain = 1 starts a timeout. The gain bit returns to 0 on the clock edge of the L-th `pd_tick` after the write, where L = 3 + 4·`tc`. A tick in the same cycle as the write is not counted.
- R4: The timeout length L covers 3 cycles for `tc` = 0 up to 63 cycles for `tc` = 15.
- R5: A gain write during an active timeout takes priority over an expiry in the same cycle. Writing 1 reloads the count from the present `tc`. Writing 0 cancels the timeout.
- R6: When `chip_en` is 0, `pwr_down` is 1 in the same cycle, whatever `pd1` and `pd2` hold.
- R7: When `chip_en` is 1, `pd1` is 1 and `pd2` is 0, `pwr_down` is 1 in the same cycle.
- R8: When `chip_en` is 1, `pd1` is 1 and `pd2` is 1, `pwr_down` stays 0 until a cycle with `pump_evt` high. It is 1 from the next cycle on, for as long as those three inputs hold.
- R9: While `pwr_down` is 1, the timeout is abandoned and ticks do not count. The gain bit keeps its value and still accepts writes.
- R10: `cp_hiz` is 1 exactly when `pwr_down`, `cp_tri` or `cnt_rst` is 1.
- R11: When timed mode is left, any running timeout stops and the gain bit keeps its value.
- R12: After reset the gain bit is 0, no timeout is running and no deferred power-down is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fl_en | input | 1 | Fastlock enable |
| fl_mode | input | 1 | Fastlock mode: 0 manual, 1 timed |
| gain_wr | input | 1 | One-cycle gain write strobe |
| gain_val | input | 1 | Value written to the gain bit |
| code_lo | input | 3 | Current setting used when gain is 0 |
| code_hi | input | 3 | Current setting used when gain is 1 |
| tc | input | 4 | Timeout select, L = 3 + 4·tc |
| pd_tick | input | 1 | One strobe per phase-detector cycle |
| pump_evt | input | 1 | Strobe marking a charge-pump up or down pulse |
| chip_en | input | 1 | Chip enable pin, low powers down |
| pd1 | input | 1 | Power-down request bit |
| pd2 | input | 1 | Power-down deferral bit |
| cp_tri | input | 1 | Explicit pump tri-state request |
| cnt_rst | input | 1 | Counter-reset request, also floats the pump |
| cp_code | output | 3 | Selected current code |
| gain_out | output | 1 | Present gain bit |
| cp_hiz | output | 1 | Pump high-impedance control |
| pwr_down | output | 1 | Power-down control |

## Verification
Two functions can act on the gain bit in the same cycle: a new gain write and the expiry of a running timeout. The bench forces this by issuing a write together with the final tick of a timeout. A reference model gives the write priority, so a write of 1 must leave the gain at 1 with a fresh count, and a write of 0 must leave it at 0. Power-down and a pending expiry also coincide in this way: a tick that arrives during a deferred or immediate power-down must not clear the gain. Long random runs mix writes, ticks, pump events and power-down bits, and every cycle is judged against the model.

// File: rtl/fastlock_cp_ctrl.sv
module fastlock_cp_ctrl #(
  parameter int CODE_W = 3,
  parameter int TC_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fl_en,
  input  logic              fl_mode,
  input  logic              gain_wr,
  input  logic              gain_val,
  input  logic [CODE_W-1:0] code_lo,
  input  logic [CODE_W-1:0] code_hi,
  input  logic [TC_W-1:0]   tc,
  input  logic              pd_tick,
  input  logic              pump_evt,
  input  logic              chip_en,
  input  logic              pd1,
  input  logic              pd2,
  input  logic              cp_tri,
  input  logic              cnt_rst,
  output logic [CODE_W-1:0] cp_code,
  output logic              gain_out,
  output logic              cp_hiz,
  output logic              pwr_down
);
  localparam int CNT_W = TC_W + 2;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             gain_q;
  logic             spd_q;
  logic [CNT_W-1:0] cnt_q;

  wire timed    = fl_en & fl_mode;
  wire sync_arm = chip_en & pd1 & pd2;
  assign pwr_down = ~chip_en | (chip_en & pd1 & ~pd2) | spd_q;
  wire run      = timed & ~pwr_down;
  wire expire   = run & pd_tick & (cnt_q == ONE);
  wire [CNT_W-1:0] load_val = {tc, 2'b11};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= 1'b0;
      spd_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      spd_q <= sync_arm & (spd_q | pump_evt);
      if (gain_wr)     gain_q <= gain_val;
      else if (expire) gain_q <= 1'b0;
      if (!run)                        cnt_q <= '0;
      else if (gain_wr)                cnt_q <= gain_val ? load_val : '0;
      else if (pd_tick && cnt_q != '0) cnt_q <= cnt_q - ONE;
    end
  end

  assign gain_out = gain_q;
  assign cp_code  = gain_q ? code_hi : code_lo;
  assign cp_hiz   = pwr_down | cp_tri | cnt_rst;
endmodule

// File: rtl/fastlock_cp_ctrl_chk.sv
module fastlock_cp_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic gain_wr,
  input logic gain_val,
  input logic pd_tick,
  input logic pump_evt,
  input logic chip_en,
  input logic pd1,
  input logic pd2,
  input logic gain_out,
  input logic cp_hiz,
  input logic pwr_down
);
  AST_PD_FLOATS: assert property (@(posedge clk) disable iff (!rst_n) pwr_down |-> cp_hiz); // R10
  AST_CE_LOW_PD: assert property (@(posedge clk) disable iff (!rst_n) !chip_en |-> pwr_down); // R6
  AST_ASYNC_PD: assert property (@(posedge clk) disable iff (!rst_n) (chip_en && pd1 && !pd2) |-> pwr_down); // R7
  AST_SYNC_PD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && pd1 && pd2 && !pwr_down && !pump_evt) ##1 (chip_en && pd1 && pd2) |-> !pwr_down); // R8
  AST_SYNC_PD_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && pd1 && pd2 && pump_evt) ##1 (chip_en && pd1 && pd2) |-> pwr_down); // R8
  AST_GAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!gain_wr && !pd_tick) |=> $stable(gain_out)); // R3
  AST_GAIN_RISE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gain_out) |-> $past(gain_wr && gain_val)); // R2
endmodule

bind fastlock_cp_ctrl fastlock_cp_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gain_wr(gain_wr), .gain_val(gain_val),
  .pd_tick(pd_tick), .pump_evt(pump_evt), .chip_en(chip_en), .pd1(pd1),
  .pd2(pd2), .gain_out(gain_out), .cp_hiz(cp_hiz), .pwr_down(pwr_down)
);

// File: tb/test_fastlock_cp_ctrl.sv
module test_fastlock_cp_ctrl;
  logic clk = 0, rst_n = 0;
  logic fl_en = 0, fl_mode = 0, gain_wr = 0, gain_val = 0;
  logic [2:0] code_lo = 3'd2, code_hi = 3'd5;
  logic [3:0] tc = 0;
  logic pd_tick = 0, pump_evt = 0, chip_en = 1, pd1 = 0, pd2 = 0, cp_tri = 0, cnt_rst = 0;
  logic [2:0] cp_code;
  logic gain_out, cp_hiz, pwr_down;

  int errors = 0, checks = 0;
  string phase = "R12";
  int mg = 0, mc = 0, ms = 0;

  always #5 clk = ~clk;

  fastlock_cp_ctrl i_fastlock_cp_ctrl (.*);

  function automatic bit m_pd();
    return !chip_en || (pd1 && !pd2) || (ms != 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mg = 0; mc = 0; ms = 0;
    end else begin
      bit pdn, run;
      pdn = m_pd();
      run = fl_en && fl_mode && !pdn;
      if (gain_wr) mg = gain_val;
      else if (run && pd_tick && mc == 1) mg = 0;
      if (!run) mc = 0;
      else if (gain_wr) mc = gain_val ? 3 + 4 * tc : 0;
      else if (pd_tick && mc > 0) mc = mc - 1;
      ms = (chip_en && pd1 && pd2 && (ms != 0 || pump_evt)) ? 1 : 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    #1;
    chk(gain_out == mg[0], {phase, " gain"}, gain_out, mg);
    chk(cp_code == (mg != 0 ? code_hi : code_lo), {phase, " code R1"}, cp_code, mg != 0 ? code_hi : code_lo);
    chk(pwr_down == m_pd(), {phase, " pwr_down"}, pwr_down, m_pd());
    chk(cp_hiz == (m_pd() || cp_tri || cnt_rst), {phase, " hiz R10"}, cp_hiz, m_pd() || cp_tri || cnt_rst);
    @(negedge clk);
  endtask

  task automatic wr(input bit v);
    gain_wr = 1; gain_val = v; step(); gain_wr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin pd_tick = 1; step(); pd_tick = 0; step(); end
  endtask

  task automatic timed_len(input int t);
    int n;
    tc = t[3:0]; wr(1); n = 0;
    for (int i = 0; i < 70; i++) begin
      pd_tick = 1; step(); pd_tick = 0; n++;
      if (!gain_out) break;
      if (i % 3 == 0) step();
    end
    chk(n == 3 + 4 * t, "R4 timeout length", n, 3 + 4 * t);
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(gain_out == 0 && cp_code == code_lo, "R12 reset state", gain_out, 0);
    rst_n = 1; step();

    phase = "R1"; fl_en = 0; wr(1); ticks(20);
    chk(gain_out == 1, "R1 manual hold", gain_out, 1);
    wr(0); fl_en = 1; fl_mode = 0; wr(1); ticks(80);
    chk(gain_out == 1, "R1 mode0 hold", gain_out, 1);
    phase = "R2"; wr(0); chk(gain_out == 0, "R2 write 0", gain_out, 0);

    phase = "R3"; fl_mode = 1; tc = 0;
    gain_wr = 1; gain_val = 1; pd_tick = 1; step(); gain_wr = 0; pd_tick = 0;
    ticks(2); chk(gain_out == 1, "R3 before expiry", gain_out, 1);
    ticks(1); chk(gain_out == 0, "R3 expiry", gain_out, 0);
    phase = "R4"; timed_len(0); timed_len(5); timed_len(15);

    phase = "R5"; tc = 2; wr(1); ticks(5); tc = 1; wr(1); ticks(6);
    chk(gain_out == 1, "R5 reload pending", gain_out, 1);
    ticks(1); chk(gain_out == 0, "R5 reload expiry", gain_out, 0);
    tc = 0; wr(1); ticks(2);
    gain_wr = 1; gain_val = 1; pd_tick = 1; step(); gain_wr = 0; pd_tick = 0;
    chk(gain_out == 1, "R5 write wins over expiry", gain_out, 1);
    ticks(2); gain_wr = 1; gain_val = 0; pd_tick = 1; step(); gain_wr = 0; pd_tick = 0;
    chk(gain_out == 0, "R5 write 0 cancels", gain_out, 0);

    phase = "R6"; pd1 = 0; chip_en = 0; #1;
    chk(pwr_down == 1, "R6 ce low", pwr_down, 1); step(); chip_en = 1; step();
    phase = "R7"; pd1 = 1; pd2 = 0; #1;
    chk(pwr_down == 1, "R7 async pd", pwr_down, 1); step();
    phase = "R8"; pd2 = 1; step(); step();
    chk(pwr_down == 0, "R8 waits for pump", pwr_down, 1'b0);
    pump_evt = 1; step(); pump_evt = 0;
    chk(pwr_down == 1, "R8 after pump", pwr_down, 1); step();
    phase = "R9"; tc = 0; wr(1); ticks(5);
    chk(gain_out == 1, "R9 no count in pd", gain_out, 1);
    pd1 = 0; pd2 = 0; step(); ticks(3);
    chk(gain_out == 1, "R9 timer abandoned", gain_out, 1);
    wr(0);

    phase = "R10"; cp_tri = 1; step(); cp_tri = 0; cnt_rst = 1; step(); cnt_rst = 0; step();
    phase = "R11"; tc = 1; wr(1); ticks(2); fl_mode = 0; step(); fl_mode = 1; ticks(10);
    chk(gain_out == 1, "R11 timer stopped", gain_out, 1);
    wr(0);

    phase = "R5 random";
    for (int i = 0; i < 20000; i++) begin
      gain_wr = ($urandom % 9) == 0; gain_val = ($urandom % 3) != 0;
      pd_tick = ($urandom % 2) == 0; pump_evt = ($urandom % 7) == 0;
      chip_en = ($urandom % 60) != 0; pd1 = ($urandom % 25) == 0 ? ~pd1 : pd1;
      pd2 = ($urandom % 25) == 0 ? ~pd2 : pd2;
      fl_en = ($urandom % 200) == 0 ? ~fl_en : fl_en;
      fl_mode = ($urandom % 200) == 0 ? ~fl_mode : fl_mode;
      tc = ($urandom % 30) == 0 ? 4'($urandom) : tc;
      cp_tri = ($urandom % 40) == 0; cnt_rst = ($urandom % 40) == 0;
      code_lo = 3'($urandom); code_hi = 3'($urandom);
      step();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule